// File: doc/BRIEF.md
# Dual-Loop Lock Detector

This block tells a demodulator when its timing recovery loop and its carrier recovery loop have settled together. For every symbol, each loop presents a signed error value, and the two values share one valid strobe. The detector adds up the absolute value of each error over an observation window of a programmable number of valid symbols. When the window closes, it compares each total with a threshold programmed for that loop.

A window passes only if both totals are strictly below their thresholds. The lock output has hysteresis. A single failing window drops lock. Lock is regained only after two passing windows in a row. The lock decision, and a one-cycle window-end pulse, appear in the clock cycle after the valid symbol that completes the window. The accumulators then start again from zero.

Top module: `loop_lock_detector`

## Requirements
- R1: After reset, lock_o and win_done_o are 0, and the first window starts with both totals at zero.
- R2: A window holds exactly win_len_m1_i+1 valid symbols, so a value of 0 gives a one-symbol window. win_done_o is high for exactly one cycle, in the cycle after the clock edge that accepts the window's last valid symbol, and is 0 in every other cycle.
- R3: Each symbol adds the magnitude of a 16-bit two's-complement error to its loop's total. The most negative code, -32768, contributes 32768.
- R4: Each total saturates at 2^ACC_W-1 instead of wrapping around.
- R5: A loop passes when its window total is strictly less than its threshold; a total equal to the threshold fails. A window passes only when both loops pass.
- R6: Both totals restart from zero at each new window, and nothing carries over from the window before.
- R7: lock_o goes high at the end of the second consecutive passing window, counted from reset or from the last failing window. After that it stays high for as long as windows keep passing.
- R8: lock_o goes low at the end of any failing window.
- R9: lock_o changes only in the cycle where win_done_o is high.
- R10: Cycles with err_valid_i low do not advance the window and do not add to either total, whatever values the error inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| err_valid_i | input | 1 | The error inputs hold one symbol's values this cycle |
| tim_err_i | input | ERR_W | Signed error from the timing loop |
| car_err_i | input | ERR_W | Signed error from the carrier loop |
| win_len_m1_i | input | CNT_W | Window length in valid symbols, minus one |
| tim_thr_i | input | ACC_W | Pass threshold for the timing total |
| car_thr_i | input | ACC_W | Pass threshold for the carrier total |
| lock_o | output | 1 | Both loops are judged locked |
| win_done_o | output | 1 | One-cycle pulse at each window end |

## Verification
Two situations are the hardest to reach from the ports. The first is total saturation: it needs a long run of full-scale errors. The bench therefore builds the block with a narrow accumulator and sends windows made only of the code -32768. One window stays one symbol below the saturation point and another goes well past it, so a design that wraps around would show a false pass. The second is the hysteresis sequence of fail, pass, pass. Directed windows reach it by choosing each threshold from the window's pre-computed total: one above the total to pass, or exactly equal to it to fail. Random windows with idle gaps then mix these cases.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  typedef enum logic [1:0] {
    LK_HUNT = 2'd0,
    LK_ONE  = 2'd1,
    LK_HELD = 2'd2
  } lock_state_e;
endpackage

// File: rtl/lkd_win_ctr.sv
module lkd_win_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [CNT_W-1:0] len_m1_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = valid_i && (cnt_q >= len_m1_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (valid_i) cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

  a_r10_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(cnt_q));
  a_r2_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> cnt_q == '0);
endmodule

// File: rtl/lkd_err_acc.sv
module lkd_err_acc #(
  parameter int ERR_W = 16,
  parameter int ACC_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    add_i,
  input  logic                    clr_i,
  input  logic signed [ERR_W-1:0] err_i,
  input  logic [ACC_W-1:0]        thr_i,
  output logic                    pass_o
);
  localparam int PAD_W = ACC_W - ERR_W;

  logic [ERR_W-1:0] mag;
  logic [ACC_W:0]   sum_ext;
  logic [ACC_W-1:0] sum_q, total;

  // two's complement magnitude, most negative code maps to 2^(ERR_W-1)
  assign mag     = err_i[ERR_W-1] ? ($unsigned(~err_i) + {{(ERR_W-1){1'b0}}, 1'b1})
                                  : $unsigned(err_i);
  assign sum_ext = {1'b0, sum_q} + {{(PAD_W+1){1'b0}}, mag};

  always_comb begin
    if (!add_i)              total = sum_q;
    else if (sum_ext[ACC_W]) total = '1;
    else                     total = sum_ext[ACC_W-1:0];
  end

  // decision uses the total including the closing symbol
  assign pass_o = total < thr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sum_q <= '0;
    else if (add_i) sum_q <= clr_i ? '0 : total;
  end

  a_r4_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i && !clr_i |=> sum_q >= $past(sum_q));
  a_r6_window_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i && clr_i |=> sum_q == '0);
  a_r3_mag_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    add_i |-> {1'b0, mag} <= (ERR_W+1)'(1) << (ERR_W-1));
endmodule

// File: rtl/lkd_lock_fsm.sv
module lkd_lock_fsm
  import lkd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic win_end_i,
  input  logic pass_i,
  output logic lock_o,
  output logic done_o
);
  lock_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (win_end_i) begin
      if (!pass_i) state_d = LK_HUNT;
      else begin
        unique case (state_q)
          LK_HUNT: state_d = LK_ONE;
          LK_ONE:  state_d = LK_HELD;
          LK_HELD: state_d = LK_HELD;
          default: state_d = LK_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LK_HUNT;
      done_o  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= win_end_i;
    end
  end

  assign lock_o = (state_q == LK_HELD);

  a_r9_lock_at_end_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end_i |=> $stable(lock_o));
  a_r8_fail_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_i && !pass_i |=> !lock_o);
  a_r7_two_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_end_i && pass_i && state_q == LK_HUNT |=> !lock_o);
endmodule

// File: rtl/loop_lock_detector.sv
module loop_lock_detector #(
  parameter int ERR_W = 16,
  parameter int ACC_W = 32,
  parameter int CNT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    err_valid_i,
  input  logic signed [ERR_W-1:0] tim_err_i,
  input  logic signed [ERR_W-1:0] car_err_i,
  input  logic [CNT_W-1:0]        win_len_m1_i,
  input  logic [ACC_W-1:0]        tim_thr_i,
  input  logic [ACC_W-1:0]        car_thr_i,
  output logic                    lock_o,
  output logic                    win_done_o
);
  localparam int N_LOOP = 2;

  logic                    win_last;
  logic [N_LOOP-1:0]       loop_pass;
  logic signed [ERR_W-1:0] err_arr [N_LOOP];
  logic [ACC_W-1:0]        thr_arr [N_LOOP];

  assign err_arr[0] = tim_err_i;
  assign err_arr[1] = car_err_i;
  assign thr_arr[0] = tim_thr_i;
  assign thr_arr[1] = car_thr_i;

  lkd_win_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (err_valid_i),
    .len_m1_i (win_len_m1_i),
    .last_o   (win_last)
  );

  for (genvar g = 0; g < N_LOOP; g++) begin : g_loop
    lkd_err_acc #(.ERR_W(ERR_W), .ACC_W(ACC_W)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .add_i  (err_valid_i),
      .clr_i  (win_last),
      .err_i  (err_arr[g]),
      .thr_i  (thr_arr[g]),
      .pass_o (loop_pass[g])
    );
  end

  lkd_lock_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_end_i (win_last),
    .pass_i    (&loop_pass),
    .lock_o    (lock_o),
    .done_o    (win_done_o)
  );

  a_r2_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_done_o |=> !win_done_o || $past(win_last));
endmodule

// File: tb/loop_lock_detector_bench.sv
module loop_lock_detector_bench;
  localparam int  ACC_W = 20;
  localparam longint SAT = (64'd1 << ACC_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic vld = 1'b0;
  logic signed [15:0] terr = '0, cerr = '0;
  logic [15:0] wlen = '0;
  logic [ACC_W-1:0] tthr = '0, cthr = '0;
  logic lock, done;

  int checks = 0, errors = 0;
  bit exp_lock = 0, exp_pp = 0;
  logic signed [15:0] et [64];
  logic signed [15:0] ec [64];

  always #5 clk = ~clk;

  loop_lock_detector #(.ERR_W(16), .ACC_W(ACC_W), .CNT_W(16)) u_loop_lock_detector (
    .clk_i(clk), .rst_ni(rst_n), .err_valid_i(vld), .tim_err_i(terr), .car_err_i(cerr),
    .win_len_m1_i(wlen), .tim_thr_i(tthr), .car_thr_i(cthr),
    .lock_o(lock), .win_done_o(done));

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic longint mag(logic signed [15:0] e);
    return (e < 0) ? -longint'(e) : longint'(e);
  endfunction

  function automatic logic signed [15:0] gen(int mode);
    case (mode)
      0: return 16'($signed(int'($urandom % 401) - 200));
      1: return 16'($urandom);
      2: return 16'sh8000;
      default: return ($urandom % 2) ? 16'sh7fff : 16'sh8000;
    endcase
  endfunction

  function automatic longint pick_thr(longint s, bit want_pass);
    longint t;
    if (want_pass) begin
      t = s + 1 + (($urandom % 2) ? 0 : longint'($urandom % 50));
      if (t > SAT) t = SAT;
    end else begin
      t = ($urandom % 2) ? s : s - longint'($urandom % (s + 1));
    end
    return t;
  endfunction

  // one window: pre-compute totals, pick thresholds, drive with idle gaps
  task automatic do_window(int n, int mode, bit pt, bit pc, bit gaps);
    longint st = 0, sc = 0, tt, tc;
    bit pass;
    for (int i = 0; i < n; i++) begin
      et[i] = gen(mode);
      ec[i] = gen(mode);
      st = st + mag(et[i]); if (st > SAT) st = SAT;
      sc = sc + mag(ec[i]); if (sc > SAT) sc = SAT;
    end
    tt = pick_thr(st, pt);
    tc = pick_thr(sc, pc);
    @(negedge clk);
    vld = 0; wlen = 16'(n - 1); tthr = ACC_W'(tt); cthr = ACC_W'(tc);
    for (int i = 0; i < n; i++) begin
      if (gaps) begin
        for (int g = 0; g < int'($urandom % 3); g++) begin
          @(negedge clk);
          vld = 0; terr = 16'sh8000; cerr = 16'sh8000 ^ 16'($urandom);
          @(posedge clk); #1;
          chk(done == 0, "R10 idle cycle gives no window end", done, 0);
        end
      end
      @(negedge clk);
      vld = 1; terr = et[i]; cerr = ec[i];
      @(posedge clk); #1;
      if (i == n - 1) begin
        pass = (st < tt) && (sc < tc);
        if (!pass) begin exp_lock = 0; exp_pp = 0; end
        else if (!exp_lock) begin
          if (exp_pp) exp_lock = 1; else exp_pp = 1;
        end
        chk(done == 1, "R2 window end pulse", done, 1);
        chk(lock == exp_lock, "R5/R7/R8 lock decision at window end", lock, exp_lock);
      end else begin
        chk(done == 0, "R2 no pulse before last symbol", done, 0);
        chk(lock == exp_lock, "R9 lock stable inside window", lock, exp_lock);
      end
    end
    @(negedge clk);
    vld = 0;
    @(posedge clk); #1;
    chk(done == 0, "R2 pulse lasts one cycle", done, 0);
    chk(lock == exp_lock, "R9 lock stable after window", lock, exp_lock);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    #1;
    chk(lock == 0, "R1 lock low in reset", lock, 0);
    chk(done == 0, "R1 done low in reset", done, 0);
    @(negedge clk); rst_n = 1;
    // R1, R7: first two passing windows from reset
    do_window(5, 0, 1, 1, 0);
    chk(lock == 0, "R7 one pass is not enough", lock, 0);
    do_window(1, 0, 1, 1, 0);  // R2 one-symbol window
    chk(lock == 1, "R7 second pass locks", lock, 1);
    do_window(8, 1, 1, 1, 1);
    // R5, R8: carrier fails alone
    do_window(6, 1, 1, 0, 0);
    chk(lock == 0, "R8 carrier failure drops lock", lock, 0);
    do_window(6, 1, 1, 1, 1);
    do_window(6, 1, 0, 1, 1);  // timing fails alone
    chk(lock == 0, "R5 timing failure blocks lock", lock, 0);
    do_window(4, 0, 1, 1, 0);
    do_window(4, 0, 1, 1, 0);
    chk(lock == 1, "R7 relock after two passes", lock, 1);
    // R3, R4: full-scale negatives just below and past saturation
    do_window(31, 2, 1, 1, 0);
    chk(lock == 1, "R3 31 x 32768 still below saturation", lock, 1);
    do_window(40, 2, 1, 1, 1);
    chk(lock == 0, "R4 saturated total fails max threshold", lock, 0);
    // R6: small windows right after a saturated one must pass
    do_window(3, 0, 1, 1, 0);
    do_window(3, 0, 1, 1, 0);
    chk(lock == 1, "R6 totals cleared between windows", lock, 1);
    do_window(20, 3, 1, 1, 1);
    for (int k = 0; k < 40; k++)
      do_window(1 + int'($urandom % 30), int'($urandom % 4),
                ($urandom % 4) != 0, ($urandom % 4) != 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule